// File: doc/BRIEF.md
# First-Order CIC Decimator with RAM Comb Delay

This block reduces a fast stream of signed samples to a slow stream whose output strobe arrives at a fixed rate. A downstream processor can use that strobe as its interrupt. A running integrator adds every accepted sample. A comb then subtracts the integrator value from `DECIM` accepted samples earlier. That older value sits in a memory delay line that runs at the input rate. The comb result is kept once every `DECIM` accepted samples and its low bits are dropped.

Because the comb delay equals the decimation ratio, each output is the sum of the most recent `DECIM` accepted inputs, truncated. With the default ratio of 256, a 160 MHz input gives a 625 kHz output. The same structure covers a ratio of 4096 (about 39 kHz) by changing only the parameter. The integrator and the comb difference both wrap in two's complement. The difference stays correct after the integrator overflows, as long as one block sum fits in the accumulator width.

Top module: `cic1_ram_decim`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `out_data` is 0.
- R2: Each output word equals bits [ACC_W-1:ACC_W-OUT_W], which are [31:8] by default, of the two's-complement sum of the last DECIM accepted inputs. Each input is sign-extended to ACC_W bits and the sum is taken modulo 2^ACC_W.
- R3: `out_valid` is a pulse one cycle long. It fires exactly once per DECIM accepted inputs, in the second cycle after the clock edge that accepts the DECIM-th input.
- R4: A cycle with `in_valid` low changes neither the sum nor the sample count, whatever value `in_data` holds.
- R5: The first output after reset is the truncated sum of the first DECIM accepted inputs. The delay line counts as zero until it has been written once in full.
- R6: The output stays correct after the running integrator has wrapped past 2^(ACC_W-1).
- R7: `out_data` keeps its value in every cycle where `out_valid` is low.
- R8: For a constant input x, every output equals (x*DECIM) >> (ACC_W-OUT_W).
- R9: The structure also works with DECIM set to 4096, following rule R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present this cycle |
| in_data | input | IN_W (16) | Signed input sample |
| out_valid | output | 1 | Single-cycle strobe marking a new output |
| out_data | output | OUT_W (24) | Truncated block sum, signed |

## Verification
The bench puts gaps with junk data between valid samples. A design that counted or added those cycles would shift its block boundaries and produce wrong sums. It also checks the very first output after reset. A design that read the memory's power-up contents before the delay line was filled would get that output wrong. A long run at full-scale positive input drives the integrator past its sign bit. Subtraction that was not modular, or that saturated, would break the outputs after that point. A second instance with a ratio of 4096 runs on the same stream. It catches any part of the design that is tied to a depth of 256.

// File: rtl/cic1_pkg.sv
package cic1_pkg;
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/cic1_integrator.sv
module cic1_integrator #(
   parameter int IN_W  = 16,
   parameter int ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_data,
   output logic [ACC_W-1:0]        integ_nxt,
   output logic [ACC_W-1:0]        integ_q
);
   localparam int EXT_W = ACC_W - IN_W;

   always_comb integ_nxt = integ_q + {{EXT_W{in_data[IN_W-1]}}, in_data};

   always_ff @(posedge clk) begin
      if (rst)           integ_q <= '0;
      else if (in_valid) integ_q <= integ_nxt;
   end

   // R4
   idle_integ_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(integ_q));
endmodule

// File: rtl/cic1_delay_ram.sv
module cic1_delay_ram #(
   parameter int ACC_W = 32,
   parameter int DEPTH = 256
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [ACC_W-1:0] wr_data,
   output logic             at_last,
   output logic [ACC_W-1:0] rd_data
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [ACC_W-1:0]  mem [DEPTH];
   logic [ACC_W-1:0]  rd_raw;
   logic [ADDR_W-1:0] addr;
   logic              filled;
   logic              rd_ok;

   always_comb at_last = (addr == LAST);

   // read-before-write at the same address: the old word leaves as the new one lands
   always_ff @(posedge clk) begin
      if (wr_en) begin
         rd_raw     <= mem[addr];
         mem[addr]  <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr   <= '0;
         filled <= 1'b0;
         rd_ok  <= 1'b0;
      end else if (wr_en) begin
         rd_ok  <= filled;
         addr   <= at_last ? '0 : addr + 1'b1;
         if (at_last) filled <= 1'b1;
      end
   end

   always_comb rd_data = rd_ok ? rd_raw : '0;

   // R4
   idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(addr));
   // R5
   fill_once_chk: assert property (@(posedge clk) disable iff (rst)
      filled |=> filled);
endmodule

// File: rtl/cic1_comb_out.sv
module cic1_comb_out #(
   parameter int ACC_W = 32,
   parameter int OUT_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [ACC_W-1:0] integ,
   input  logic [ACC_W-1:0] delayed,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);
   localparam int DROP = ACC_W - OUT_W;

   logic [ACC_W-1:0] diff;
   logic [OUT_W-1:0] kept;

   always_comb diff = integ - delayed;

   generate
      if (DROP == 0) begin : g_full
         always_comb kept = diff;
      end else begin : g_trunc
         always_comb kept = diff[ACC_W-1:DROP];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= tick;
         if (tick) out_data <= kept;
      end
   end

   // R3
   pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(out_data));
endmodule

// File: rtl/cic1_ram_decim.sv
module cic1_ram_decim #(
   parameter int IN_W  = 16,
   parameter int ACC_W = 32,
   parameter int OUT_W = 24,
   parameter int DECIM = 256
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_data,
   output logic                    out_valid,
   output logic [OUT_W-1:0]        out_data
);
   import cic1_pkg::*;

   localparam int ADDR_W = $clog2(DECIM);

   initial begin
      assert (is_pow2(DECIM) && DECIM >= 2) else $fatal(1, "DECIM must be a power of two >= 2");
      assert (ACC_W >= IN_W + ADDR_W) else $fatal(1, "ACC_W too small for bit growth");
      assert (OUT_W <= ACC_W && OUT_W > 0) else $fatal(1, "OUT_W out of range");
   end

   logic [ACC_W-1:0] integ_nxt;
   logic [ACC_W-1:0] integ_q;
   logic [ACC_W-1:0] delayed;
   logic             at_last;
   logic             s1_tick;

   cic1_integrator #(.IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .integ_nxt(integ_nxt), .integ_q(integ_q)
   );

   cic1_delay_ram #(.ACC_W(ACC_W), .DEPTH(DECIM)) u_dly (
      .clk(clk), .rst(rst), .wr_en(in_valid), .wr_data(integ_nxt),
      .at_last(at_last), .rd_data(delayed)
   );

   always_ff @(posedge clk) begin
      if (rst) s1_tick <= 1'b0;
      else     s1_tick <= in_valid && at_last;
   end

   cic1_comb_out #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_comb (
      .clk(clk), .rst(rst), .tick(s1_tick), .integ(integ_q), .delayed(delayed),
      .out_valid(out_valid), .out_data(out_data)
   );

   // R3
   strobe_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && at_last) |-> ##2 out_valid);
   // R3
   no_stray_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && at_last) |-> ##2 !out_valid);
endmodule

// File: tb/cic1_ram_decim_tb.sv
`timescale 1ns/1ps
module cic1_ram_decim_tb;
   localparam int CLK_PERIOD = 10;
   localparam int IN_W = 16, ACC_W = 32, OUT_W = 24;
   localparam int DA = 256, DB = 4096;

   typedef struct { logic [OUT_W-1:0] d; string tag; } exp_t;

   logic clk = 0, rst = 1, in_valid = 0;
   logic signed [IN_W-1:0] in_data = '0;
   logic va, vb;
   logic [OUT_W-1:0] da, db;

   exp_t qa[$], qb[$];
   int n_checks = 0, n_err = 0;
   int pushed_a = 0, pushed_b = 0, seen_a = 0, seen_b = 0;
   logic [ACC_W-1:0] acc_a = '0, acc_b = '0;
   int cnt_a = 0, cnt_b = 0;
   string cur_tag = "R5";
   logic prev_va = 0, prev_vb = 0;
   logic [OUT_W-1:0] last_a = '0, last_b = '0;
   exp_t ea, eb;

   always #(CLK_PERIOD/2) clk = ~clk;

   cic1_ram_decim #(.IN_W(IN_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .DECIM(DA)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(va), .out_data(da));
   cic1_ram_decim #(.IN_W(IN_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .DECIM(DB)) u_dut_big (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(vb), .out_data(db));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: applies one cycle and updates the reference model
   task automatic drive(input bit v, input logic [IN_W-1:0] x);
      exp_t e;
      @(negedge clk);
      in_valid = v;
      in_data  = x;
      if (v) begin
         acc_a += {{(ACC_W-IN_W){x[IN_W-1]}}, x};
         acc_b += {{(ACC_W-IN_W){x[IN_W-1]}}, x};
         cnt_a++; cnt_b++;
         if (cnt_a == DA) begin
            e.d = acc_a[ACC_W-1:ACC_W-OUT_W]; e.tag = cur_tag;
            qa.push_back(e); pushed_a++; acc_a = '0; cnt_a = 0;
            if (cur_tag == "R5") cur_tag = "R2";
         end
         if (cnt_b == DB) begin
            e.d = acc_b[ACC_W-1:ACC_W-OUT_W]; e.tag = "R9";
            qb.push_back(e); pushed_b++; acc_b = '0; cnt_b = 0;
         end
      end
   endtask

   // monitor / scoreboard for both instances
   always @(negedge clk) begin
      if (!rst) begin
         if (va) begin
            seen_a++;
            chk(!prev_va, "R3 pulse width", 1, 0);
            if (qa.size() == 0) chk(0, "R3 unexpected strobe", da, 0);
            else begin
               ea = qa.pop_front();
               chk(da == ea.d, ea.tag, da, ea.d);
            end
            last_a = da;
         end else chk(da == last_a, "R7 hold", da, last_a);
         if (vb) begin
            seen_b++;
            if (qb.size() == 0) chk(0, "R9 unexpected strobe", db, 0);
            else begin
               eb = qb.pop_front();
               chk(db == eb.d, eb.tag, db, eb.d);
            end
            last_b = db;
         end
         prev_va = va;
         prev_vb = vb;
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      // R1: reset state
      repeat (4) @(negedge clk);
      chk(va == 0 && da == 0, "R1 in reset", {va, da}, 0);
      rst = 0;
      @(negedge clk);
      chk(va == 0 && da == 0, "R1 after reset", {va, da}, 0);

      // R5/R2/R4: random data with idle gaps carrying junk
      for (int i = 0; i < 3 * DA; i++) begin
         logic [31:0] r = $urandom;
         if (r[20:19] == 2'b00) drive(1'b0, 16'hDEAD);
         drive(1'b1, r[15:0]);
      end
      // R2: full-scale negative block
      for (int i = 0; i < DA; i++) drive(1'b1, 16'h8000);
      // R2: ramp through the sign boundary, with every other cycle idle (R4)
      for (int i = 0; i < DA; i++) begin
         drive(1'b1, 16'(i * 131 - 16000));
         drive(1'b0, 16'h7FFF);
      end
      // R8/R6: long constant full-scale run wraps the integrator
      cur_tag = "R8";
      for (int i = 0; i < 70000; i++) begin
         if (i == 66000) cur_tag = "R6";
         drive(1'b1, 16'h7FFF);
      end
      drive(1'b0, 16'h0);
      repeat (6) @(negedge clk);
      // R3: strobe count equals blocks completed
      chk(seen_a == pushed_a && qa.size() == 0, "R3 strobe count", seen_a, pushed_a);
      chk(seen_b == pushed_b && qb.size() == 0, "R9 strobe count", seen_b, pushed_b);
      summary();
   end
endmodule